// File: doc/BRIEF.md
# Debug Breakpoint and Watchpoint Hit Qualifier

This block sits behind an array of breakpoint and watchpoint address comparators. Each comparator reports a raw address-match hit and carries a 32-bit control word. The block decides whether that hit becomes a debug event. It takes into account the processor's security state, its current exception level, a global monitor-debug enable, a signal saying whether debug exceptions are currently allowed, and an optional link to a context-ID breakpoint.

A comparator whose link flag is set qualifies only when the breakpoint it names also passes. That named breakpoint must have a valid index, must be enabled, must be of the context-ID type, and must hold the live context ID in its value register. The block computes no addresses, builds no syndrome and does not enter an exception. It produces one registered event pulse, a flag saying whether a watchpoint or a breakpoint fired, and the index of the winning comparator.

Top module: `dbg_hit_qualifier`

## Requirements
- R1: No event is raised unless both `mon_dbg_en` and `dbg_allowed` are 1 in the cycle of the raw hit.
- R2: The security selector in control bits 15:14 works as follows: 0 qualifies in either state, 1 and 3 qualify only when `secure` is 0, and 2 qualifies only when `secure` is 1.
- R3: The privilege check depends on the level. At levels 2 and 3 a hit needs control bit 13. At level 1 it needs control bit 1. At level 0 it needs control bit 2.
- R4: A watchpoint hit with its `wp_unpriv` bit set gets the level-0 privilege check of R3, whatever the value of `cur_el`.
- R5: When control bit 20 (link flag) is set, the link number in bits 19:16 must lie between NUM_BP-NUM_CTX and NUM_BP-1 inclusive. Otherwise the hit is rejected.
- R6: A linked breakpoint passes only if all of these hold: its bit 0 (enable) is 1, its type field in bits 23:20 equals 3, the actual `cur_el` is 0 or 1, and `ctx_id` equals its 32-bit value register. Every other type fails.
- R7: When several comparators qualify in the same cycle, a breakpoint wins over a watchpoint, and within each kind the lowest index wins.
- R8: A hit that qualifies in cycle N drives `evt_valid` high in cycle N+1, together with `evt_is_wp` (1 means watchpoint) and `evt_idx`. With no qualified hit, `evt_valid` is low in the next cycle.
- R9: While `rst` is high, `evt_valid` is held low on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mon_dbg_en | input | 1 | Global monitor-debug enable |
| dbg_allowed | input | 1 | Debug exceptions currently permitted |
| secure | input | 1 | Processor is in secure state |
| cur_el | input | 2 | Current exception level 0..3 |
| ctx_id | input | 32 | Current context ID |
| bp_hit | input | NUM_BP | Raw breakpoint address hits |
| bp_ctrl | input | NUM_BP*32 | Breakpoint control words, slot i at bits [32i+31:32i] |
| bp_value | input | NUM_BP*32 | Breakpoint value registers (low 32 bits), slot i at bits [32i+31:32i] |
| wp_hit | input | NUM_WP | Raw watchpoint hits |
| wp_ctrl | input | NUM_WP*32 | Watchpoint control words, slot i at bits [32i+31:32i] |
| wp_unpriv | input | NUM_WP | Watchpoint hit came from an unprivileged-access load or store |
| evt_valid | output | 1 | Registered one-cycle debug event |
| evt_is_wp | output | 1 | Event source is a watchpoint |
| evt_idx | output | IDX_W (3) | Index of the winning comparator |

## Verification
The bench sweeps every combination of security selector, privilege bits, higher-mode bit, level and security state on one breakpoint. A design that decodes selector value 3 as secure-only, or swaps the two privilege bits, fails in that sweep. A second sweep covers every link number from 0 to 15 against every target type, enable and context match, at levels 0 to 2. It catches an off-by-one in the link range, a linked test that is still allowed at level 2, and an unprivileged watchpoint whose level override wrongly reaches the linked context test. Randomised multi-hit cycles check that breakpoints win over watchpoints and that the lowest index wins. A single-cycle hit followed by an idle cycle checks that the event pulses instead of holding.

// File: rtl/dbgq_pkg.sv
package dbgq_pkg;

    localparam int CTRL_W = 32;
    localparam int CTX_W  = 32;

    // Control word layout, MSB first. The link flag is the LSB of kind.
    typedef struct packed {
        logic [7:0] rsvd_hi;
        logic [3:0] kind;
        logic [3:0] link_num;
        logic [1:0] sec_sel;
        logic       hyp_ok;
        logic [9:0] rsvd_mid;
        logic [1:0] lvl_ok;
        logic       en;
    } dbg_ctrl_t;

    localparam logic [3:0] KIND_CTX_MATCH = 4'd3;

    function automatic logic sec_pass(input logic [1:0] sel, input logic is_sec);
        logic r;
        unique case (sel)
            2'd0:    r = 1'b1;
            2'd2:    r = is_sec;
            default: r = !is_sec;
        endcase
        return r;
    endfunction

    function automatic logic lvl_pass(input dbg_ctrl_t c, input logic [1:0] el);
        logic r;
        unique case (el)
            2'd0:    r = c.lvl_ok[1];
            2'd1:    r = c.lvl_ok[0];
            default: r = c.hyp_ok;
        endcase
        return r;
    endfunction

    function automatic logic link_flag(input dbg_ctrl_t c);
        return c.kind[0];
    endfunction

endpackage

// File: rtl/dbgq_link_eval.sv
module dbgq_link_eval
    import dbgq_pkg::*;
#(
    parameter int NUM_BP  = 6,
    parameter int NUM_CTX = 2
) (
    input  dbg_ctrl_t              bp_cw  [NUM_BP],
    input  logic [CTX_W-1:0]       bp_val [NUM_BP],
    input  logic [1:0]             cur_el,
    input  logic [CTX_W-1:0]       ctx_id,
    output logic [NUM_BP-1:0]      link_ok
);
    localparam int FIRST_CTX = NUM_BP - NUM_CTX;

    logic low_el;
    assign low_el = (cur_el <= 2'd1);

    for (genvar i = 0; i < NUM_BP; i++) begin : g_tgt
        if (i >= FIRST_CTX) begin : g_ctx
            assign link_ok[i] = bp_cw[i].en
                              && (bp_cw[i].kind == KIND_CTX_MATCH)
                              && low_el
                              && (ctx_id == bp_val[i]);
        end else begin : g_plain
            assign link_ok[i] = 1'b0;
        end
    end

endmodule

// File: rtl/dbgq_slot_qual.sv
module dbgq_slot_qual
    import dbgq_pkg::*;
#(
    parameter int NUM_BP  = 6,
    parameter int NUM_CTX = 2
) (
    input  logic              raw_hit,
    input  dbg_ctrl_t         cw,
    input  logic              unpriv,
    input  logic              secure,
    input  logic [1:0]        cur_el,
    input  logic [NUM_BP-1:0] link_ok,
    output logic              qual
);
    localparam int FIRST_CTX = NUM_BP - NUM_CTX;

    logic [1:0] eff_el;
    logic       lnk_sel;

    assign eff_el = unpriv ? 2'd0 : cur_el;

    always_comb begin
        lnk_sel = 1'b0;
        for (int j = FIRST_CTX; j < NUM_BP; j++) begin
            if (cw.link_num == 4'(j)) lnk_sel = link_ok[j];
        end
    end

    assign qual = raw_hit
               && sec_pass(cw.sec_sel, secure)
               && lvl_pass(cw, eff_el)
               && (!link_flag(cw) || lnk_sel);

endmodule

// File: rtl/dbgq_first.sv
module dbgq_first #(
    parameter int N  = 6,
    parameter int IW = 3
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/dbg_hit_qualifier.sv
module dbg_hit_qualifier
    import dbgq_pkg::*;
#(
    parameter  int NUM_BP  = 6,
    parameter  int NUM_WP  = 4,
    parameter  int NUM_CTX = 2,
    localparam int MAX_N   = (NUM_BP > NUM_WP) ? NUM_BP : NUM_WP,
    localparam int IDX_W   = (MAX_N > 1) ? $clog2(MAX_N) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     mon_dbg_en,
    input  logic                     dbg_allowed,
    input  logic                     secure,
    input  logic [1:0]               cur_el,
    input  logic [CTX_W-1:0]         ctx_id,
    input  logic [NUM_BP-1:0]        bp_hit,
    input  logic [NUM_BP*CTRL_W-1:0] bp_ctrl,
    input  logic [NUM_BP*CTX_W-1:0]  bp_value,
    input  logic [NUM_WP-1:0]        wp_hit,
    input  logic [NUM_WP*CTRL_W-1:0] wp_ctrl,
    input  logic [NUM_WP-1:0]        wp_unpriv,
    output logic                     evt_valid,
    output logic                     evt_is_wp,
    output logic [IDX_W-1:0]         evt_idx
);
    dbg_ctrl_t         bp_cw  [NUM_BP];
    dbg_ctrl_t         wp_cw  [NUM_WP];
    logic [CTX_W-1:0]  bp_val [NUM_BP];
    logic [NUM_BP-1:0] link_ok;
    logic [NUM_BP-1:0] bp_qual;
    logic [NUM_WP-1:0] wp_qual;
    logic              bp_found, wp_found, gate;
    logic [IDX_W-1:0]  bp_idx, wp_idx;

    for (genvar i = 0; i < NUM_BP; i++) begin : g_bp_unpack
        assign bp_cw[i]  = bp_ctrl[i*CTRL_W +: CTRL_W];
        assign bp_val[i] = bp_value[i*CTX_W +: CTX_W];
    end
    for (genvar i = 0; i < NUM_WP; i++) begin : g_wp_unpack
        assign wp_cw[i] = wp_ctrl[i*CTRL_W +: CTRL_W];
    end

    dbgq_link_eval #(.NUM_BP(NUM_BP), .NUM_CTX(NUM_CTX)) u_link (
        .bp_cw(bp_cw), .bp_val(bp_val), .cur_el(cur_el),
        .ctx_id(ctx_id), .link_ok(link_ok)
    );

    for (genvar i = 0; i < NUM_BP; i++) begin : g_bp
        dbgq_slot_qual #(.NUM_BP(NUM_BP), .NUM_CTX(NUM_CTX)) u_slot (
            .raw_hit(bp_hit[i]), .cw(bp_cw[i]), .unpriv(1'b0),
            .secure(secure), .cur_el(cur_el), .link_ok(link_ok),
            .qual(bp_qual[i])
        );

        // R2
        sec_sel_chk: assert property (@(posedge clk) disable iff (rst)
            (bp_qual[i] && secure) |-> (bp_cw[i].sec_sel == 2'd0 || bp_cw[i].sec_sel == 2'd2));

        // R3
        hyp_bit_chk: assert property (@(posedge clk) disable iff (rst)
            (bp_qual[i] && cur_el >= 2'd2) |-> bp_cw[i].hyp_ok);
    end

    for (genvar i = 0; i < NUM_WP; i++) begin : g_wp
        dbgq_slot_qual #(.NUM_BP(NUM_BP), .NUM_CTX(NUM_CTX)) u_slot (
            .raw_hit(wp_hit[i]), .cw(wp_cw[i]), .unpriv(wp_unpriv[i]),
            .secure(secure), .cur_el(cur_el), .link_ok(link_ok),
            .qual(wp_qual[i])
        );

        // R6
        link_low_el_chk: assert property (@(posedge clk) disable iff (rst)
            (wp_qual[i] && wp_cw[i].kind[0]) |-> (cur_el <= 2'd1));
    end

    dbgq_first #(.N(NUM_BP), .IW(IDX_W)) u_bp_pick (
        .req(bp_qual), .found(bp_found), .idx(bp_idx)
    );
    dbgq_first #(.N(NUM_WP), .IW(IDX_W)) u_wp_pick (
        .req(wp_qual), .found(wp_found), .idx(wp_idx)
    );

    assign gate = mon_dbg_en && dbg_allowed;

    always_ff @(posedge clk) begin
        if (rst) begin
            evt_valid <= 1'b0;
            evt_is_wp <= 1'b0;
            evt_idx   <= '0;
        end else begin
            evt_valid <= gate && (bp_found || wp_found);
            evt_is_wp <= !bp_found && wp_found;
            evt_idx   <= bp_found ? bp_idx : wp_idx;
        end
    end

    // R1
    gate_off_chk: assert property (@(posedge clk) disable iff (rst)
        !(mon_dbg_en && dbg_allowed) |=> !evt_valid);

    // R7
    bp_over_wp_chk: assert property (@(posedge clk) disable iff (rst)
        (gate && |bp_qual) |=> (evt_valid && !evt_is_wp));

    // R8
    pulse_src_chk: assert property (@(posedge clk) disable iff (rst)
        evt_valid |-> $past(|{bp_hit, wp_hit}));

    // R9
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> !evt_valid);

endmodule

// File: tb/tb_dbg_hit_qualifier.sv
module tb_dbg_hit_qualifier;
    localparam int NB = 6;
    localparam int NW = 4;
    localparam int NC = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    bit [31:0] bc [NB];
    bit [31:0] bv [NB];
    bit [31:0] wc [NW];
    bit [NB-1:0] bh;
    bit [NW-1:0] wh, wu;
    bit en_g, allow_g, sec;
    bit [1:0] el;
    bit [31:0] ctx;

    logic [NB*32-1:0] bp_ctrl_p, bp_val_p;
    logic [NW*32-1:0] wp_ctrl_p;
    logic evt_valid, evt_is_wp;
    logic [2:0] evt_idx;

    always_comb begin
        for (int i = 0; i < NB; i++) begin
            bp_ctrl_p[i*32 +: 32] = bc[i];
            bp_val_p[i*32 +: 32]  = bv[i];
        end
        for (int i = 0; i < NW; i++) wp_ctrl_p[i*32 +: 32] = wc[i];
    end

    dbg_hit_qualifier #(.NUM_BP(NB), .NUM_WP(NW), .NUM_CTX(NC)) dut (
        .clk(clk), .rst(rst), .mon_dbg_en(en_g), .dbg_allowed(allow_g),
        .secure(sec), .cur_el(el), .ctx_id(ctx),
        .bp_hit(bh), .bp_ctrl(bp_ctrl_p), .bp_value(bp_val_p),
        .wp_hit(wh), .wp_ctrl(wp_ctrl_p), .wp_unpriv(wu),
        .evt_valid(evt_valid), .evt_is_wp(evt_is_wp), .evt_idx(evt_idx)
    );

    int n_chk = 0;
    int n_bad = 0;

    // Reference model, written from the requirements.
    function automatic bit ref_link(bit [3:0] k);
        bit [31:0] t;
        if (k > NB - 1 || k < NB - NC) return 0;            // R5
        t = bc[k];
        return t[0] && t[23:20] == 4'd3 && el <= 1 && ctx == bv[k];  // R6
    endfunction

    function automatic bit ref_qual(bit [31:0] c, bit up);
        int e;
        bit ok;
        e = up ? 0 : int'(el);                              // R4
        case (c[15:14])                                      // R2
            2'd0: ok = 1;
            2'd2: ok = sec;
            default: ok = !sec;
        endcase
        if (e >= 2) ok = ok && c[13];                        // R3
        else if (e == 1) ok = ok && c[1];
        else ok = ok && c[2];
        if (c[20]) ok = ok && ref_link(c[19:16]);
        return ok;
    endfunction

    bit e_v, e_w;
    int e_i;

    task automatic predict();
        e_v = 0; e_w = 0; e_i = 0;
        if (!(en_g && allow_g)) return;                      // R1
        for (int i = NB - 1; i >= 0; i--)
            if (bh[i] && ref_qual(bc[i], 0)) begin e_v = 1; e_i = i; end
        if (e_v) return;
        for (int i = NW - 1; i >= 0; i--)
            if (wh[i] && ref_qual(wc[i], wu[i])) begin e_v = 1; e_w = 1; e_i = i; end
    endtask

    task automatic step(input string tag);
        predict();
        @(posedge clk);
        #2;
        n_chk++;
        if (evt_valid !== e_v || (e_v && (evt_is_wp !== e_w || int'(evt_idx) != e_i))) begin
            n_bad++;
            $display("FAIL %s: got v=%0b w=%0b i=%0d exp v=%0b w=%0b i=%0d",
                     tag, evt_valid, evt_is_wp, evt_idx, e_v, e_w, e_i);
        end
    endtask

    task automatic clear_all();
        for (int i = 0; i < NB; i++) begin bc[i] = 0; bv[i] = 0; end
        for (int i = 0; i < NW; i++) wc[i] = 0;
        bh = 0; wh = 0; wu = 0; sec = 0; el = 0; ctx = 0;
        en_g = 1; allow_g = 1;
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog: run did not complete");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        clear_all();
        bh = 1; bc[0] = 32'h0000_2006;
        // R9: held in reset with a qualifying hit present
        for (int k = 0; k < 3; k++) begin
            @(posedge clk); #2;
            n_chk++;
            if (evt_valid !== 1'b0) begin
                n_bad++;
                $display("FAIL R9 reset: got v=%0b exp v=0", evt_valid);
            end
        end
        rst = 1'b0;
        clear_all();
        step("R8 idle after reset");

        // R2 R3: full sweep on breakpoint 0
        for (int s = 0; s < 2; s++)
            for (int e = 0; e < 4; e++)
                for (int ss = 0; ss < 4; ss++)
                    for (int p = 0; p < 4; p++)
                        for (int h = 0; h < 2; h++) begin
                            clear_all();
                            sec = s[0]; el = e[1:0];
                            bc[0] = {16'h0, ss[1:0], h[0], 10'h0, p[1:0], 1'b1};
                            bh = 6'b000001;
                            step("R2 R3 sec/priv sweep");
                        end

        // R4: unprivileged watchpoint on slot 2
        for (int u = 0; u < 2; u++)
            for (int e = 0; e < 4; e++)
                for (int p = 0; p < 4; p++)
                    for (int h = 0; h < 2; h++) begin
                        clear_all();
                        el = e[1:0];
                        wc[2] = {16'h0, 2'b00, h[0], 10'h0, p[1:0], 1'b1};
                        wh = 4'b0100; wu = {1'b0, u[0], 2'b00};
                        step("R4 unpriv watchpoint");
                    end

        // R5 R6: link number, target type, enable, context, level
        for (int k = 0; k < 16; k++)
            for (int t = 0; t < 16; t++)
                for (int m = 0; m < 2; m++)
                    for (int en = 0; en < 2; en++)
                        for (int e = 0; e < 3; e++) begin
                            clear_all();
                            el = e[1:0];
                            ctx = 32'hA5C3_1E07;
                            bc[1] = {8'h0, 4'b0001, k[3:0], 2'b00, 1'b1, 10'h0, 2'b11, 1'b1};
                            bc[4] = {8'h0, t[3:0], 4'h0, 2'b00, 1'b0, 10'h0, 2'b00, en[0]};
                            bc[5] = {8'h0, t[3:0], 4'h0, 2'b00, 1'b0, 10'h0, 2'b00, en[0]};
                            bv[4] = m[0] ? ctx : ctx ^ 32'h0000_0100;
                            bv[5] = m[0] ? ctx : ctx ^ 32'h8000_0000;
                            bc[3] = bc[4]; bv[3] = ctx;   // non-context-aware target
                            bh = 6'b000010;
                            step("R5 R6 linked sweep");
                        end

        // R4 R6: unprivileged watchpoint at level 2 with a link keeps the real level
        clear_all();
        el = 2'd2; ctx = 32'h1234_5678;
        bc[5] = {8'h0, 4'd3, 4'h0, 2'b00, 1'b0, 10'h0, 2'b00, 1'b1}; bv[5] = ctx;
        wc[0] = {8'h0, 4'b0001, 4'd5, 2'b00, 1'b0, 10'h0, 2'b10, 1'b1};
        wh = 4'b0001; wu = 4'b0001;
        step("R4 R6 unpriv linked at level 2");

        // R1: gating inputs
        for (int g = 0; g < 4; g++) begin
            clear_all();
            en_g = g[0]; allow_g = g[1];
            bc[2] = 32'h0000_0006; bh = 6'b000100;
            step("R1 gate");
        end

        // R8: single-cycle pulse
        clear_all();
        bc[0] = 32'h0000_0006; bh = 1;
        step("R8 pulse high");
        bh = 0;
        step("R8 pulse drop");

        // R7: randomised multi-hit priority
        for (int n = 0; n < 3000; n++) begin
            clear_all();
            en_g = ($urandom_range(0, 7) != 0);
            allow_g = ($urandom_range(0, 7) != 0);
            sec = 1'($urandom); el = 2'($urandom);
            ctx = ($urandom_range(0, 1) != 0) ? 32'h0BAD_F00D : $urandom;
            for (int i = 0; i < NB; i++) begin
                bc[i] = $urandom & 32'h00FF_E007;
                bv[i] = ($urandom_range(0, 1) != 0) ? 32'h0BAD_F00D : $urandom;
            end
            for (int i = 0; i < NW; i++) wc[i] = $urandom & 32'h00FF_E007;
            bh = 6'($urandom) & 6'($urandom);
            wh = 4'($urandom);
            wu = 4'($urandom);
            step("R7 random priority");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule